// File: doc/BRIEF.md
# Single-Wire Ratio-Coded Command Receiver

This block is the slave end of a one-pin command link that sets a backlight brightness level. The host toggles a single open-drain control line. Every bit spans the interval between two consecutive falling edges, and its value comes from how long the line stays low compared with how long it stays high inside that interval. The bit rate is therefore not fixed. The receiver samples the line with its own free-running clock, after a two-flop synchroniser, and measures both phases in clock counts with saturating counters.

A frame has two bytes, sent most significant bit first. The first byte is a fixed device address. After it comes a separator: a short low, then the line held high for an end-of-stream time. The second byte is the data byte. Its top bit requests an acknowledge, the next two bits are a sub-address, and the low five bits are the brightness code. When the address matches and all sixteen bits decode cleanly, the receiver loads the code. The code is also mapped to a feedback reference in millivolts on a piecewise-linear curve. If an acknowledge was requested, the receiver asserts a pull-down enable for a fixed time. An open-drain pad outside the block turns that enable into a low on the line.

A bit whose ratio fits neither rule, or a separator that is too short, throws the frame away. A line that stays silent for too long drops any partial frame.

Top module: `ratio_cmd_rx`

## Requirements
- R1: After reset, level_code is 31, level_mv is 200 and ack_pull is 0.
- R2: A bit is decoded as 1 when its high count is at least twice its low count, and as 0 when its low count is at least twice its high count. An exact 2:1 ratio qualifies. Decoding works at any phase length the counters can hold.
- R3: A frame is address bits 7..0 then data bits 7..0, MSB first, and each bit is closed by the next falling edge. The data byte is laid out as bit 7 = acknowledge request, bits 6:5 = sub-address (not checked), bits 4:0 = code. On acceptance, level_code takes the code 3 clock edges after the closing falling edge reaches line_in.
- R4: If the address byte is not DEV_ADDR (default 0x72), level_code does not change and ack_pull stays 0.
- R5: A bit whose ratio satisfies neither rule discards the frame: there is no update and no acknowledge. Falling edges are then ignored until the line has had no falling edge for TIMEOUT_CYC cycles, after which the next frame is accepted.
- R6: A separator between the bytes whose high phase is shorter than EOS_CYC cycles discards the frame in the same way as R5.
- R7: If no falling edge arrives for TIMEOUT_CYC cycles while a frame is in progress, the partial frame is dropped, and the next falling edge starts a new frame.
- R8: An accepted frame with the request bit set drives ack_pull high for exactly ACK_LEN_CYC cycles, starting ACK_DLY_CYC cycles after level_code updates. Falling edges during the acknowledge are ignored. With the request bit clear, ack_pull stays 0.
- R9: level_mv is 0 for code 0 and 5 for code 1. It rises 3 per code up to code 12 (38), then 6 per code up to code 23 (104), then 12 per code up to code 31 (200).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 1 | Asynchronous control line level |
| level_code | output | 5 | Stored brightness code |
| level_mv | output | 8 | Reference level in millivolts for level_code |
| ack_pull | output | 1 | Open-drain pull-down enable for the acknowledge |

## Verification
If a phase counter is wrong, or the bit index is off by one, the receiver shifts the wrong bits. That shows up as a wrong level_code three edges after the closing edge of a frame, or as a missing or spurious acknowledge window. If the frame state is stuck, the fault appears at the next frame: a frame sent after a timeout or discard is rejected or misaligned, so it is visible within one frame time. The reference model predicts the exact edge of every code update and the exact first and last cycle of every ack_pull pulse, so even a one-cycle slip is caught.

// File: rtl/ratio_cmd_pkg.sv
`timescale 1ns/1ps
// Shared types for the ratio-coded command receiver.
package ratio_cmd_pkg;

    // Frame sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SEP,
        ST_DATA,
        ST_DISCARD,
        ST_ACK_WAIT,
        ST_ACK_ON
    } rx_state_t;

    localparam int unsigned BYTE_BITS = 8;
    localparam int unsigned CODE_BITS = 5;

endpackage

// File: rtl/line_sync_edge.sv
`timescale 1ns/1ps
// Two-flop synchroniser plus a falling-edge detector for the control line.
// Assumes the line idles high, so all stages reset to 1 and no edge is
// reported out of reset.
module line_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s,
    output logic fall
);
    logic s1, s2, s3;

    // Shift the raw line through the synchroniser and a history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= line_in;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign line_s = s2;
    assign fall   = s3 & ~s2;
endmodule

// File: rtl/ratio_bit_decoder.sv
`timescale 1ns/1ps
// Measures the low and high phases of the current falling-to-falling period
// with saturating counters and classifies the period at the closing edge.
// Also counts cycles since the last falling edge for the frame timeout.
// Assumes the fall flag comes from line_sync_edge (line_s already low).
module ratio_bit_decoder #(
    parameter int unsigned CNT_W       = 17,
    parameter int unsigned TIMEOUT_CYC = 200000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_s,
    input  logic             fall,
    output logic             bit_one,
    output logic             bit_zero,
    output logic [CNT_W-1:0] hi_cnt,
    output logic             quiet_hit
);
    localparam int unsigned QW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] lo_cnt;
    logic [QW-1:0]    quiet;

    // Phase counters: restart on a falling edge, else count the sampled level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_cnt <= '0;
            hi_cnt <= '0;
        end else if (fall) begin
            lo_cnt <= CNT_W'(1);
            hi_cnt <= '0;
        end else if (line_s) begin
            hi_cnt <= (hi_cnt == CNT_MAX) ? hi_cnt : hi_cnt + 1'b1;
        end else begin
            lo_cnt <= (lo_cnt == CNT_MAX) ? lo_cnt : lo_cnt + 1'b1;
        end
    end

    // Quiet counter: cycles since the last falling edge, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quiet <= '0;
        end else if (fall) begin
            quiet <= '0;
        end else if (quiet != QW'(TIMEOUT_CYC)) begin
            quiet <= quiet + 1'b1;
        end
    end

    assign quiet_hit = (quiet == QW'(TIMEOUT_CYC));
    assign bit_one   = ({1'b0, hi_cnt} >= {lo_cnt, 1'b0});
    assign bit_zero  = ({1'b0, lo_cnt} >= {hi_cnt, 1'b0});

    AST_HIGH_BEFORE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        fall |-> (hi_cnt != '0)); // R2
    AST_RATIO_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        fall |-> !(bit_one && bit_zero)); // R2
endmodule

// File: rtl/frame_sequencer.sv
`timescale 1ns/1ps
// Frame sequencer: collects the address byte, checks the inter-byte
// separator, collects the data byte, loads the code and times the
// acknowledge. Bit values come from ratio_bit_decoder at each falling edge.
// Assumes ACK_DLY_CYC and ACK_LEN_CYC are at least 1.
module frame_sequencer
    import ratio_cmd_pkg::*;
#(
    parameter int unsigned CNT_W       = 17,
    parameter int unsigned EOS_CYC     = 400,
    parameter int unsigned ACK_DLY_CYC = 400,
    parameter int unsigned ACK_LEN_CYC = 100000,
    parameter logic [7:0]  DEV_ADDR    = 8'h72
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fall,
    input  logic                 bit_one,
    input  logic                 bit_zero,
    input  logic [CNT_W-1:0]     hi_cnt,
    input  logic                 quiet_hit,
    output logic [CODE_BITS-1:0] code_q,
    output logic                 ack_pull
);
    localparam int unsigned ACK_MAX = (ACK_DLY_CYC > ACK_LEN_CYC) ? ACK_DLY_CYC : ACK_LEN_CYC;
    localparam int unsigned AW      = $clog2(ACK_MAX + 1);
    localparam int unsigned IW      = $clog2(BYTE_BITS);

    rx_state_t           state;
    logic [IW-1:0]       bit_idx;
    logic [BYTE_BITS-2:0] sr;
    logic [BYTE_BITS-1:0] shifted;
    logic                addr_ok;
    logic [AW-1:0]       ack_cnt;
    logic                bit_ok;
    logic                last_bit;

    assign shifted  = {sr, bit_one};
    assign bit_ok   = bit_one | bit_zero;
    assign last_bit = (bit_idx == IW'(BYTE_BITS - 1));

    // Main frame state machine with shift register, code register and ack timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_idx <= '0;
            sr      <= '0;
            addr_ok <= 1'b0;
            ack_cnt <= '0;
            code_q  <= CODE_BITS'(31);
        end else begin
            case (state)
                ST_IDLE: begin
                    if (fall) begin
                        state   <= ST_ADDR;
                        bit_idx <= '0;
                    end
                end
                ST_ADDR: begin
                    if (quiet_hit) begin
                        state <= ST_IDLE;
                    end else if (fall) begin
                        if (!bit_ok) begin
                            state <= ST_DISCARD;
                        end else begin
                            sr <= shifted[BYTE_BITS-2:0];
                            if (last_bit) begin
                                addr_ok <= (shifted == DEV_ADDR);
                                state   <= ST_SEP;
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                            end
                        end
                    end
                end
                ST_SEP: begin
                    if (quiet_hit) begin
                        state <= ST_IDLE;
                    end else if (fall) begin
                        if (hi_cnt < CNT_W'(EOS_CYC)) begin
                            state <= ST_DISCARD;
                        end else begin
                            state   <= ST_DATA;
                            bit_idx <= '0;
                        end
                    end
                end
                ST_DATA: begin
                    if (quiet_hit) begin
                        state <= ST_IDLE;
                    end else if (fall) begin
                        if (!bit_ok) begin
                            state <= ST_DISCARD;
                        end else begin
                            sr <= shifted[BYTE_BITS-2:0];
                            if (last_bit) begin
                                if (addr_ok) begin
                                    code_q <= shifted[CODE_BITS-1:0];
                                    if (shifted[BYTE_BITS-1]) begin
                                        state   <= ST_ACK_WAIT;
                                        ack_cnt <= '0;
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                            end
                        end
                    end
                end
                ST_DISCARD: begin
                    if (quiet_hit) begin
                        state <= ST_IDLE;
                    end
                end
                ST_ACK_WAIT: begin
                    if (ack_cnt == AW'(ACK_DLY_CYC - 1)) begin
                        state   <= ST_ACK_ON;
                        ack_cnt <= '0;
                    end else begin
                        ack_cnt <= ack_cnt + 1'b1;
                    end
                end
                ST_ACK_ON: begin
                    if (ack_cnt == AW'(ACK_LEN_CYC - 1)) begin
                        state   <= ST_IDLE;
                        ack_cnt <= '0;
                    end else begin
                        ack_cnt <= ack_cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign ack_pull = (state == ST_ACK_ON);

    AST_CODE_ONLY_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_q) |-> ($past(state) == ST_DATA && $past(fall) && $past(addr_ok))); // R4
    AST_ACK_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_pull) |-> ($past(state) == ST_ACK_WAIT)); // R8
    AST_ACK_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK_ON) |-> (ack_cnt < AW'(ACK_LEN_CYC))); // R8
    AST_TIMEOUT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_ADDR || state == ST_SEP || state == ST_DATA || state == ST_DISCARD)
         && quiet_hit) |=> (state == ST_IDLE)); // R7
    AST_BAD_BIT_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_ADDR || state == ST_DATA) && fall && !bit_one && !bit_zero && !quiet_hit)
        |=> (state == ST_DISCARD)); // R5
endmodule

// File: rtl/level_map.sv
`timescale 1ns/1ps
// Maps the 5-bit brightness code to a reference level in millivolts on a
// three-segment curve (3, 6, then 12 mV per code). Purely combinational.
// Eight-bit wraparound in the top segment is intended: the final value fits.
module level_map
    import ratio_cmd_pkg::*;
#(
    parameter int unsigned KNEE_A = 12,
    parameter int unsigned KNEE_B = 23
) (
    input  logic [CODE_BITS-1:0] code,
    output logic [7:0]           mv
);
    logic [7:0] c8;
    assign c8 = {3'b000, code};

    // Select the segment and evaluate its line.
    always_comb begin
        if (c8 == 8'd0) begin
            mv = 8'd0;
        end else if (c8 <= 8'(KNEE_A)) begin
            mv = 8'd3 * c8 + 8'd2;
        end else if (c8 <= 8'(KNEE_B)) begin
            mv = 8'd6 * c8 - 8'd34;
        end else begin
            mv = 8'd12 * c8 - 8'd172;
        end
    end
endmodule

// File: rtl/ratio_cmd_rx.sv
`timescale 1ns/1ps
// Top of the single-wire ratio-coded command receiver. Chains the line
// synchroniser, the ratio bit decoder, the frame sequencer and the level map.
// Assumes line_in is asynchronous and the pad outside turns ack_pull into an
// open-drain low on the same line.
module ratio_cmd_rx
    import ratio_cmd_pkg::*;
#(
    parameter int unsigned CNT_W       = 17,
    parameter int unsigned TIMEOUT_CYC = 200000,
    parameter int unsigned EOS_CYC     = 400,
    parameter int unsigned ACK_DLY_CYC = 400,
    parameter int unsigned ACK_LEN_CYC = 100000,
    parameter logic [7:0]  DEV_ADDR    = 8'h72
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_in,
    output logic [4:0] level_code,
    output logic [7:0] level_mv,
    output logic       ack_pull
);
    logic             line_s;
    logic             fall;
    logic             bit_one;
    logic             bit_zero;
    logic [CNT_W-1:0] hi_cnt;
    logic             quiet_hit;

    line_sync_edge u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (line_in),
        .line_s  (line_s),
        .fall    (fall)
    );

    ratio_bit_decoder #(
        .CNT_W       (CNT_W),
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_s    (line_s),
        .fall      (fall),
        .bit_one   (bit_one),
        .bit_zero  (bit_zero),
        .hi_cnt    (hi_cnt),
        .quiet_hit (quiet_hit)
    );

    frame_sequencer #(
        .CNT_W       (CNT_W),
        .EOS_CYC     (EOS_CYC),
        .ACK_DLY_CYC (ACK_DLY_CYC),
        .ACK_LEN_CYC (ACK_LEN_CYC),
        .DEV_ADDR    (DEV_ADDR)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall      (fall),
        .bit_one   (bit_one),
        .bit_zero  (bit_zero),
        .hi_cnt    (hi_cnt),
        .quiet_hit (quiet_hit),
        .code_q    (level_code),
        .ack_pull  (ack_pull)
    );

    level_map u_map (
        .code (level_code),
        .mv   (level_mv)
    );

    AST_MAP_FULL_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
        (level_code == 5'd31) |-> (level_mv == 8'd200)); // R9
    AST_MAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (level_code == 5'd0) |-> (level_mv == 8'd0)); // R9
endmodule

// File: tb/ratio_cmd_rx_bench.sv
`timescale 1ns/1ps
module ratio_cmd_rx_bench;
    localparam int TO  = 600;
    localparam int EOS = 10;
    localparam int DLY = 12;
    localparam int LEN = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host = 1'b1;
    logic line;
    logic [4:0] level_code;
    logic [7:0] level_mv;
    logic ack_pull;

    always #2.5 clk = ~clk;
    assign line = host & ~ack_pull;

    ratio_cmd_rx #(
        .CNT_W(12), .TIMEOUT_CYC(TO), .EOS_CYC(EOS),
        .ACK_DLY_CYC(DLY), .ACK_LEN_CYC(LEN), .DEV_ADDR(8'h72)
    ) u_ratio_cmd_rx (
        .clk(clk), .rst_n(rst_n), .line_in(line),
        .level_code(level_code), .level_mv(level_mv), .ack_pull(ack_pull)
    );

    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    run_chk = 0;
    bit    done = 0;
    int    exp_code = 31;
    bit    pend_valid = 0;
    int    pend_code = 0;
    int    pend_at = 0;
    int    ack_from = -1;
    int    ack_to = -1;
    int    ack_seen = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Expected millivolts by accumulating per-code increments.
    function automatic int mv_of(input int c);
        int v = 0;
        for (int k = 1; k <= c; k++) begin
            if (k == 1) v += 5;
            else if (k <= 12) v += 3;
            else if (k <= 23) v += 6;
            else v += 12;
        end
        return v;
    endfunction

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Per-clock comparison against the behavioural model.
    always @(negedge clk) begin
        if (run_chk) begin
            if (pend_valid && cyc >= pend_at) begin
                exp_code = pend_code;
                pend_valid = 0;
            end
            chk(cur_req, level_code, exp_code, "level_code");
            chk("R9", level_mv, mv_of(exp_code), "level_mv");
            chk(cur_req, ack_pull, (cyc >= ack_from && cyc < ack_to) ? 1 : 0, "ack_pull");
            if (ack_pull) ack_seen++;
        end
    end

    task automatic drive(input logic v, input int n);
        host = v;
        repeat (n) @(negedge clk);
    endtask

    // Sends one frame; bit 1 = low s, high m*s; bit 0 = low m*s, high s.
    task automatic send_frame(input logic [7:0] a, input logic [7:0] d, input int s, input int m,
                              input int sep_hi, input int bad_pos);
        bit ok;
        int k;
        int tail;
        ok = (a == 8'h72) && (bad_pos < 0) && (sep_hi >= EOS);
        for (int idx = 0; idx < 16; idx++) begin
            logic b;
            if (idx == 8) begin
                drive(1'b0, 6);
                drive(1'b1, sep_hi);
            end
            b = (idx < 8) ? a[7 - idx] : d[15 - idx];
            if (idx == bad_pos) begin
                drive(1'b0, 10); drive(1'b1, 15);
            end else if (b) begin
                drive(1'b0, s); drive(1'b1, m * s);
            end else begin
                drive(1'b0, m * s); drive(1'b1, s);
            end
        end
        k = cyc + 1;
        if (ok) begin
            pend_code = d[4:0];
            pend_at = k + 2;
            pend_valid = 1;
            if (d[7]) begin
                ack_from = k + 2 + DLY;
                ack_to = ack_from + LEN;
            end
        end
        tail = ok ? (DLY + LEN + 40) : (TO + 60);
        drive(1'b0, 6);
        drive(1'b1, tail);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        run_chk = 1;
        @(negedge clk);
        chk("R1", level_code, 31, "reset code");
        chk("R1", level_mv, 200, "reset mv");
        chk("R1", ack_pull, 0, "reset ack");
        repeat (10) @(negedge clk);

        cur_req = "R3";
        send_frame(8'h72, 8'h0D, 8, 3, 30, -1);
        chk("R3", level_code, 13, "code 13");
        chk("R9", level_mv, 44, "mv code 13");

        cur_req = "R8";
        ack_seen = 0;
        send_frame(8'h72, 8'h85, 8, 3, 30, -1);
        chk("R8", level_code, 5, "code 5 with ack");
        chk("R8", ack_seen, LEN, "ack length");

        cur_req = "R4";
        ack_seen = 0;
        send_frame(8'h73, 8'h9F, 8, 3, 30, -1);
        chk("R4", level_code, 5, "wrong address keeps code");
        chk("R4", ack_seen, 0, "wrong address no ack");

        cur_req = "R2";
        send_frame(8'h72, 8'h17, 3, 3, 30, -1);
        chk("R2", level_code, 23, "fast rate code 23");
        chk("R9", level_mv, 104, "mv code 23");
        send_frame(8'h72, 8'h18, 50, 3, 30, -1);
        chk("R2", level_code, 24, "slow rate code 24");
        send_frame(8'h72, 8'h6A, 10, 2, 30, -1);
        chk("R2", level_code, 10, "exact 2:1 ratio, sub-address ignored");

        cur_req = "R5";
        ack_seen = 0;
        send_frame(8'h72, 8'h81, 8, 3, 30, 12);
        chk("R5", level_code, 10, "ambiguous bit discards");
        chk("R5", ack_seen, 0, "ambiguous bit no ack");
        send_frame(8'h72, 8'h0C, 8, 3, 30, -1);
        chk("R5", level_code, 12, "accepted after discard");
        chk("R9", level_mv, 38, "mv code 12");

        cur_req = "R6";
        send_frame(8'h72, 8'h02, 8, 3, 4, -1);
        chk("R6", level_code, 12, "short separator discards");

        cur_req = "R7";
        for (int i = 0; i < 4; i++) begin
            drive(1'b0, 8); drive(1'b1, 24);
        end
        drive(1'b1, TO + 60);
        send_frame(8'h72, 8'h00, 8, 3, 30, -1);
        chk("R7", level_code, 0, "new frame after timeout");
        chk("R9", level_mv, 0, "mv code 0");
        send_frame(8'h72, 8'h01, 8, 3, 30, -1);
        chk("R9", level_mv, 5, "mv code 1");

        cur_req = "R8";
        ack_seen = 0;
        send_frame(8'h72, 8'h9F, 8, 3, 30, -1);
        chk("R8", level_code, 31, "code 31 with ack");
        chk("R8", ack_seen, LEN, "second ack length");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule